// File: doc/BRIEF.md
# Output-Buffer-Full Host Interrupt Generator

This block drives the host interrupt line of one host-interface channel. It keeps the output-buffer-full flag, which the embedded controller sets by writing the output buffer and the host clears by reading it. The flag is turned into an interrupt line in one of two styles. In level style the line is active for as long as the flag is set. In edge style the line idles at one level and gives a pulse of programmed length each time the flag becomes set.

A configuration register holds four settings. A width field picks the style: zero selects level, and any nonzero value selects edge with that pulse length. A polarity bit inverts the line in either style. A source bit drives the line from a firmware-written level instead of the flag, and a fourth field holds that level. The controller can read the present line value back on a status output. Bus decode, interrupt routing and serialization are outside this block.

Top module: `obf_irq_gen`

## Requirements
- R1: After reset the flag is clear, the width is zero (level style), polarity is normal, the hardware source is selected, and both `irq_line` and `irq_status` are 0.
- R2: A cycle with `ob_wr` high and `ob_rd` low sets `obf` at the next clock edge.
- R3: A cycle with `ob_rd` high clears `obf` at the next clock edge, also when `ob_wr` is high in the same cycle.
- R4: With width 0, the hardware source and normal polarity, `irq_line` equals `obf`.
- R5: With a nonzero width N, the hardware source and normal polarity, `irq_line` idles at 1. When `obf` rises at a clock edge, the line is 0 for exactly N cycles, starting one edge later.
- R6: A new rise of `obf` during an active pulse reloads the pulse length, so the pulse ends N cycles after the edge that follows the new rise.
- R7: With `cfg_invert` = 1, `irq_line` is the complement of the normal-polarity line in both level and edge style.
- R8: With `cfg_src_fw` = 1, `irq_line` equals `cfg_fw_level` XOR `cfg_invert`, and changes of `obf` have no effect on it.
- R9: `irq_status` always carries the present value of `irq_line`.
- R10: A configuration write with `cfg_we` high takes effect at the next edge. Writing width 0 during a pulse ends the pulse, so a later return to edge style starts idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ob_wr | input | 1 | Controller writes the output buffer |
| ob_rd | input | 1 | Host reads the output buffer |
| cfg_we | input | 1 | Load the configuration register |
| cfg_width | input | PW | Style and pulse length: 0 selects level, N > 0 selects an edge pulse of N cycles |
| cfg_invert | input | 1 | 1 inverts the line |
| cfg_src_fw | input | 1 | 1 drives the line from the firmware level |
| cfg_fw_level | input | 1 | Firmware-written interrupt level |
| obf | output | 1 | Output-buffer-full flag |
| irq_line | output | 1 | Host interrupt line |
| irq_status | output | 1 | Readback of the line value |

## Verification
The bench sweeps every nonzero pulse width of a 3-bit field under both polarities and samples the line on every cycle around each flag rise. This shows off-by-one errors in the pulse start or length apart from polarity errors. Level style is tried under both polarities with set, clear and the simultaneous write-and-read case, which tests the clear priority. A read followed by a rewrite during a pulse shows whether the counter reloads. All four firmware-level and polarity pairs are driven while the flag toggles, which shows any leak from the hardware path. Switching the width to zero during a pulse and then back shows whether a stale count survives.

// File: rtl/irqgen_pkg.sv
package irqgen_pkg;
  typedef enum logic { SRC_HW = 1'b0, SRC_FW = 1'b1 } irq_src_e;
  typedef enum logic { STYLE_LEVEL = 1'b0, STYLE_EDGE = 1'b1 } irq_style_e;
endpackage

// File: rtl/irqgen_rst_sync.sv
module irqgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irqgen_cfg.sv
module irqgen_cfg
  import irqgen_pkg::*;
#(
  parameter int unsigned PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] width_in,
  input  logic          invert_in,
  input  logic          src_fw_in,
  input  logic          fw_level_in,
  output logic [PW-1:0] width_q,
  output logic          invert_q,
  output irq_src_e      src_q,
  output logic          fw_level_q
);
  logic [PW-1:0] width_d;
  logic          invert_d;
  irq_src_e      src_d;
  logic          fw_level_d;

  always_comb begin
    width_d    = width_q;
    invert_d   = invert_q;
    src_d      = src_q;
    fw_level_d = fw_level_q;
    if (we) begin
      width_d    = width_in;
      invert_d   = invert_in;
      src_d      = src_fw_in ? SRC_FW : SRC_HW;
      fw_level_d = fw_level_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q    <= '0;
      invert_q   <= 1'b0;
      src_q      <= SRC_HW;
      fw_level_q <= 1'b0;
    end else begin
      width_q    <= width_d;
      invert_q   <= invert_d;
      src_q      <= src_d;
      fw_level_q <= fw_level_d;
    end
  end
endmodule

// File: rtl/irqgen_obf.sv
module irqgen_obf (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic rd,
  output logic flag,
  output logic rise
);
  logic flag_d, prev_q;

  always_comb begin
    flag_d = flag;
    if (rd)      flag_d = 1'b0;
    else if (wr) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      flag   <= flag_d;
      prev_q <= flag;
    end
  end

  assign rise = flag & ~prev_q;
endmodule

// File: rtl/irqgen_pulse.sv
module irqgen_pulse #(
  parameter int unsigned PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] width,
  input  logic          trigger,
  output logic          active
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          edge_mode;

  assign edge_mode = (width != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!edge_mode)          cnt_d = '0;
    else if (trigger)        cnt_d = width;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/obf_irq_gen.sv
module obf_irq_gen
  import irqgen_pkg::*;
#(
  parameter int unsigned PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ob_wr,
  input  logic          ob_rd,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_width,
  input  logic          cfg_invert,
  input  logic          cfg_src_fw,
  input  logic          cfg_fw_level,
  output logic          obf,
  output logic          irq_line,
  output logic          irq_status
);
  logic          rst_n_s;
  logic [PW-1:0] width_q;
  logic          invert_q;
  irq_src_e      src_q;
  logic          fw_level_q;
  logic          obf_rise;
  logic          pulse_on;
  irq_style_e    style;
  logic          hw_normal;
  logic          pre_pol;

  irqgen_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_s)
  );

  irqgen_cfg #(.PW(PW)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .we(cfg_we),
    .width_in(cfg_width), .invert_in(cfg_invert),
    .src_fw_in(cfg_src_fw), .fw_level_in(cfg_fw_level),
    .width_q(width_q), .invert_q(invert_q),
    .src_q(src_q), .fw_level_q(fw_level_q)
  );

  irqgen_obf u_obf (
    .clk(clk), .rst_n(rst_n_s), .wr(ob_wr), .rd(ob_rd),
    .flag(obf), .rise(obf_rise)
  );

  irqgen_pulse #(.PW(PW)) u_pulse (
    .clk(clk), .rst_n(rst_n_s), .width(width_q),
    .trigger(obf_rise), .active(pulse_on)
  );

  always_comb begin
    style = (width_q == '0) ? STYLE_LEVEL : STYLE_EDGE;
    case (style)
      STYLE_LEVEL: hw_normal = obf;
      default:     hw_normal = ~pulse_on;
    endcase
    pre_pol  = (src_q == SRC_FW) ? fw_level_q : hw_normal;
    irq_line = pre_pol ^ invert_q;
  end

  assign irq_status = irq_line;
endmodule

// File: rtl/obf_irq_chk.sv
module obf_irq_chk #(
  parameter int unsigned PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic          rd,
  input logic          obf,
  input logic          line,
  input logic [PW-1:0] width,
  input logic          inv,
  input logic          fw_sel,
  input logic          fw_bit
);
  assert_obf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd) |=> obf);

  assert_rd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !obf);

  assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (width == '0 && !fw_sel) |-> (line == (obf ^ inv)));

  // R5 and R7: after a flag rise in edge style the line is active one edge later
  assert_edge_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (width != '0 && !fw_sel && $rose(obf)) |=>
      (width == '0 || fw_sel || line == inv));

  assert_fw_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fw_sel |-> (line == (fw_bit ^ inv)));
endmodule

bind obf_irq_gen obf_irq_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .wr(ob_wr), .rd(ob_rd), .obf(obf),
  .line(irq_line), .width(width_q), .inv(invert_q),
  .fw_sel(src_q == irqgen_pkg::SRC_FW), .fw_bit(fw_level_q)
);

// File: tb/tb_obf_irq_gen.sv
module tb_obf_irq_gen;
  localparam int unsigned PW = 3;
  localparam int unsigned MAXW = (1 << PW) - 1;

  logic clk, rst_n, ob_wr, ob_rd, cfg_we, cfg_invert, cfg_src_fw, cfg_fw_level;
  logic [PW-1:0] cfg_width;
  logic obf, irq_line, irq_status;
  int checks = 0, errors = 0, cycles = 0;

  obf_irq_gen #(.PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .ob_wr(ob_wr), .ob_rd(ob_rd),
    .cfg_we(cfg_we), .cfg_width(cfg_width), .cfg_invert(cfg_invert),
    .cfg_src_fw(cfg_src_fw), .cfg_fw_level(cfg_fw_level),
    .obf(obf), .irq_line(irq_line), .irq_status(irq_status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int w, input logic inv, input logic fw, input logic fb);
    cfg_we = 1'b1; cfg_width = w[PW-1:0]; cfg_invert = inv;
    cfg_src_fw = fw; cfg_fw_level = fb;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_wr();
    ob_wr = 1'b1; @(negedge clk); ob_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    ob_rd = 1'b1; @(negedge clk); ob_rd = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; ob_wr = 1'b0; ob_rd = 1'b0; cfg_we = 1'b0;
    cfg_width = '0; cfg_invert = 1'b0; cfg_src_fw = 1'b0; cfg_fw_level = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 obf", obf, 1'b0);
    chk("R1 line", irq_line, 1'b0);
    chk("R1 status", irq_status, 1'b0);

    // R4 / R7 / R9 level style, both polarities
    for (int inv = 0; inv < 2; inv++) begin
      set_cfg(0, inv[0], 1'b0, 1'b0);
      chk("R4/R7 level idle", irq_line, inv[0]);
      pulse_wr();
      chk("R2 set", obf, 1'b1);
      chk("R4/R7 level active", irq_line, ~inv[0]);
      chk("R9 status", irq_status, irq_line);
      pulse_rd();
      chk("R3 clear", obf, 1'b0);
      chk("R4/R7 level released", irq_line, inv[0]);
    end

    // R3 priority of read over write
    ob_wr = 1'b1; ob_rd = 1'b1; @(negedge clk); ob_wr = 1'b0; ob_rd = 1'b0;
    chk("R3 both while clear", obf, 1'b0);
    pulse_wr();
    ob_wr = 1'b1; ob_rd = 1'b1; @(negedge clk); ob_wr = 1'b0; ob_rd = 1'b0;
    chk("R3 both while set", obf, 1'b0);

    // R5 / R7 edge style sweep of every width and polarity
    for (int inv = 0; inv < 2; inv++) begin
      for (int w = 1; w <= int'(MAXW); w++) begin
        set_cfg(w, inv[0], 1'b0, 1'b0);
        chk("R5 idle", irq_line, ~inv[0]);
        ob_wr = 1'b1;
        for (int i = 1; i <= w + 3; i++) begin
          @(negedge clk);
          ob_wr = 1'b0;
          chk("R5/R7 edge pulse", irq_line,
              ((i >= 2) && (i <= w + 1)) ? inv[0] : ~inv[0]);
        end
        pulse_rd();
        @(negedge clk);
      end
    end

    // R6 restart during an active pulse (width 4)
    set_cfg(4, 1'b0, 1'b0, 1'b0);
    ob_wr = 1'b1;
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      chk("R6 restart", irq_line, ((i >= 2) && (i <= 7)) ? 1'b0 : 1'b1);
      ob_wr = (i == 2);
      ob_rd = (i == 1);
    end
    ob_wr = 1'b0; ob_rd = 1'b0;
    pulse_rd();

    // R8 firmware source, obf changes ignored
    for (int inv = 0; inv < 2; inv++) begin
      for (int fb = 0; fb < 2; fb++) begin
        set_cfg(3, inv[0], 1'b1, fb[0]);
        chk("R8 fw line", irq_line, fb[0] ^ inv[0]);
        ob_wr = 1'b1;
        for (int i = 1; i <= 5; i++) begin
          @(negedge clk);
          ob_wr = 1'b0;
          chk("R8 obf ignored", irq_line, fb[0] ^ inv[0]);
        end
        pulse_rd();
        chk("R8 after clear", irq_line, fb[0] ^ inv[0]);
      end
    end

    // R10 width zero cancels a pulse (inverted, width 7)
    set_cfg(int'(MAXW), 1'b1, 1'b0, 1'b0);
    pulse_wr();
    chk("R10 not yet active", irq_line, 1'b0);
    @(negedge clk);
    chk("R10 pulse active", irq_line, 1'b1);
    set_cfg(0, 1'b1, 1'b0, 1'b0);
    chk("R10 level after write", irq_line, 1'b0);
    @(negedge clk);
    set_cfg(int'(MAXW), 1'b1, 1'b0, 1'b0);
    chk("R10 edge resumes idle", irq_line, 1'b0);
    @(negedge clk);
    chk("R10 stays idle", irq_line, 1'b0);
    chk("R9 status idle", irq_status, 1'b0);
    pulse_rd();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule